// File: doc/BRIEF.md
# Next Program Counter Unit

This block picks the address of the next instruction for a 32-bit RISC core. Each cycle it takes the current program counter, a decoded transfer code, two register operands, a 16-bit branch displacement, a 26-bit direct-jump field and a register-held jump address. One clock edge later it presents the next program counter, a flag that says whether control left the sequential path, and a request to write a return address into the register file.

Conditional transfers come in two kinds. A branch on two registers tests only equality or inequality. A branch on one register reads it as a signed number and compares it with zero. The displacement counts instructions, not bytes, and is measured from the instruction that follows the branch. Unconditional transfers are a direct jump, which splices a 26-bit word index under the top bits of the sequential address, and a jump to an address held in a register. Both have a variant that also saves the return address. The block is used between decode and fetch. Its registered outputs feed the fetch address multiplexer and the register-file write port.

Top module: `npc_unit`

## Requirements
- R1: While `rst_n` is low, `npc_o` is 0 and `taken_o` and `link_we_o` are 0.
- R2: Code 1 (branch if equal) and code 2 (branch if not equal) compare `rs_val_i` with `rt_val_i` over all 32 bits. When the branch is taken, the target is PC + 4 + (sign-extended `off_i` shifted left by 2).
- R3: Codes 3, 4, 5 and 6 branch when `rs_val_i`, read as a two's-complement number, is greater than zero, less than zero, at least zero, or at most zero, respectively. The target is the same as in R2.
- R4: When no transfer is taken, `npc_o` is PC + 4, `taken_o` is 0 and `link_we_o` is 0.
- R5: Code 7 (direct jump) is always taken. Its target is bits 31..28 of PC + 4, followed by `jtgt_i`, followed by two zero bits.
- R6: Code 8 jumps exactly as code 7 does. It also requests a link write to register 31 with the value PC + 4.
- R7: Code 9 is always taken and sets `npc_o` to `jreg_i`.
- R8: Code 10 jumps as code 9 does. It also requests a link write of PC + 4 to register `link_rd_i`. The write is suppressed when `link_rd_i` is 0.
- R9: Codes 0 and 11 to 15 mean no transfer.
- R10: Every output reflects the inputs sampled at the previous rising clock edge, and holds its value until the next rising edge.
- R11: All address arithmetic wraps modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| pc_i | input | 32 | Address of the current instruction |
| xfer_i | input | 4 | Decoded transfer code |
| rs_val_i | input | 32 | First register operand |
| rt_val_i | input | 32 | Second register operand |
| off_i | input | 16 | Signed branch displacement in instructions |
| jtgt_i | input | 26 | Direct-jump word index field |
| jreg_i | input | 32 | Register-held jump address |
| link_rd_i | input | 5 | Destination register of a register jump with link |
| npc_o | output | 32 | Next program counter |
| taken_o | output | 1 | Control left the sequential path |
| link_we_o | output | 1 | Link write request |
| link_rd_o | output | 5 | Link destination register |
| link_val_o | output | 32 | Return address to write |

## Verification
The bench builds the unit with its default widths: a 32-bit address, a 16-bit displacement, a 26-bit jump field, 5-bit register indices and register 31 as the fixed link target. At these widths the sweep reaches the exact sign boundaries 0x7FFFFFFF and 0x80000000, together with zero, one and minus one. It runs every transfer code, both extreme displacements (0x7FFF and 0x8000), and program counters that make the sequential address, the branch sum and the top four jump bits wrap or cross a region.

// File: rtl/npc_pkg.sv
package npc_pkg;

  localparam int XFER_W = 4;

  typedef enum logic [XFER_W-1:0] {
    XF_NONE      = 4'd0,
    XF_BR_EQ     = 4'd1,
    XF_BR_NE     = 4'd2,
    XF_BR_GTZ    = 4'd3,
    XF_BR_LTZ    = 4'd4,
    XF_BR_GEZ    = 4'd5,
    XF_BR_LEZ    = 4'd6,
    XF_JDIR      = 4'd7,
    XF_JDIR_LINK = 4'd8,
    XF_JREG      = 4'd9,
    XF_JREG_LINK = 4'd10
  } xfer_e;

  typedef enum logic [1:0] {
    SRC_SEQ = 2'd0,
    SRC_BR  = 2'd1,
    SRC_DIR = 2'd2,
    SRC_REG = 2'd3
  } tgt_src_e;

  typedef struct packed {
    tgt_src_e src;
    logic     link;
    logic     link_fixed;
  } xfer_class_t;

endpackage

// File: rtl/npc_decode.sv
module npc_decode
  import npc_pkg::*;
(
  input  logic [XFER_W-1:0] xfer_i,
  output xfer_class_t       cls_o
);

  always_comb begin
    cls_o = '{src: SRC_SEQ, link: 1'b0, link_fixed: 1'b0};
    case (xfer_i)
      XF_BR_EQ, XF_BR_NE, XF_BR_GTZ,
      XF_BR_LTZ, XF_BR_GEZ, XF_BR_LEZ: cls_o.src = SRC_BR;
      XF_JDIR: cls_o.src = SRC_DIR;
      XF_JDIR_LINK: begin
        cls_o.src        = SRC_DIR;
        cls_o.link       = 1'b1;
        cls_o.link_fixed = 1'b1;
      end
      XF_JREG: cls_o.src = SRC_REG;
      XF_JREG_LINK: begin
        cls_o.src  = SRC_REG;
        cls_o.link = 1'b1;
      end
      default: cls_o.src = SRC_SEQ;
    endcase
  end

endmodule

// File: rtl/npc_cond.sv
module npc_cond
  import npc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XFER_W-1:0] xfer_i,
  input  logic [XLEN-1:0]   rs_i,
  input  logic [XLEN-1:0]   rt_i,
  output logic              cond_o
);

  logic ops_equal;
  logic rs_negative;
  logic rs_zero;

  assign ops_equal   = (rs_i == rt_i);
  assign rs_negative = rs_i[XLEN-1];
  assign rs_zero     = (rs_i == '0);

  always_comb begin
    case (xfer_i)
      XF_BR_EQ:  cond_o = ops_equal;
      XF_BR_NE:  cond_o = !ops_equal;
      XF_BR_GTZ: cond_o = !rs_negative && !rs_zero;
      XF_BR_LTZ: cond_o = rs_negative;
      XF_BR_GEZ: cond_o = !rs_negative;
      XF_BR_LEZ: cond_o = rs_negative || rs_zero;
      default:   cond_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/npc_target.sv
module npc_target #(
  parameter int XLEN  = 32,
  parameter int OFF_W = 16,
  parameter int JT_W  = 26
) (
  input  logic [XLEN-1:0]  pc_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic [JT_W-1:0]  jtgt_i,
  output logic [XLEN-1:0]  seq_o,
  output logic [XLEN-1:0]  br_o,
  output logic [XLEN-1:0]  dir_o
);

  localparam int INSN_SHIFT = 2;
  localparam int HI_W       = XLEN - JT_W - INSN_SHIFT;
  localparam int EXT_W      = XLEN - OFF_W;

  function automatic logic [XLEN-1:0] f_seq(input logic [XLEN-1:0] pc);
    return pc + XLEN'(1 << INSN_SHIFT);
  endfunction

  function automatic logic [XLEN-1:0] f_branch(input logic [XLEN-1:0]  seq,
                                               input logic [OFF_W-1:0] off);
    logic [XLEN-1:0] ext;
    ext = {{EXT_W{off[OFF_W-1]}}, off};
    return seq + (ext << INSN_SHIFT);
  endfunction

  function automatic logic [XLEN-1:0] f_direct(input logic [XLEN-1:0] seq,
                                               input logic [JT_W-1:0] jt);
    return {seq[XLEN-1 -: HI_W], jt, {INSN_SHIFT{1'b0}}};
  endfunction

  assign seq_o = f_seq(pc_i);
  assign br_o  = f_branch(seq_o, off_i);
  assign dir_o = f_direct(seq_o, jtgt_i);

endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int OFF_W    = 16,
  parameter int JT_W     = 26,
  parameter int RA_W     = 5,
  parameter int LINK_IDX = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [XLEN-1:0]   pc_i,
  input  logic [XFER_W-1:0] xfer_i,
  input  logic [XLEN-1:0]   rs_val_i,
  input  logic [XLEN-1:0]   rt_val_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [JT_W-1:0]   jtgt_i,
  input  logic [XLEN-1:0]   jreg_i,
  input  logic [RA_W-1:0]   link_rd_i,
  output logic [XLEN-1:0]   npc_o,
  output logic              taken_o,
  output logic              link_we_o,
  output logic [RA_W-1:0]   link_rd_o,
  output logic [XLEN-1:0]   link_val_o
);

  localparam logic [RA_W-1:0] FIXED_RD = RA_W'(LINK_IDX);

  xfer_class_t     cls_w;
  logic            cond_w;
  logic [XLEN-1:0] seq_w;
  logic [XLEN-1:0] br_w;
  logic [XLEN-1:0] dir_w;

  logic            take_w;
  logic [XLEN-1:0] next_w;
  logic [RA_W-1:0] dest_w;
  logic            link_req_w;

  npc_decode u_dec (
    .xfer_i (xfer_i),
    .cls_o  (cls_w)
  );

  npc_cond #(.XLEN(XLEN)) u_cond (
    .xfer_i (xfer_i),
    .rs_i   (rs_val_i),
    .rt_i   (rt_val_i),
    .cond_o (cond_w)
  );

  npc_target #(.XLEN(XLEN), .OFF_W(OFF_W), .JT_W(JT_W)) u_tgt (
    .pc_i   (pc_i),
    .off_i  (off_i),
    .jtgt_i (jtgt_i),
    .seq_o  (seq_w),
    .br_o   (br_w),
    .dir_o  (dir_w)
  );

  always_comb begin
    case (cls_w.src)
      SRC_BR:  take_w = cond_w;
      SRC_DIR: take_w = 1'b1;
      SRC_REG: take_w = 1'b1;
      default: take_w = 1'b0;
    endcase
  end

  always_comb begin
    next_w = seq_w;
    if (take_w) begin
      case (cls_w.src)
        SRC_BR:  next_w = br_w;
        SRC_DIR: next_w = dir_w;
        SRC_REG: next_w = jreg_i;
        default: next_w = seq_w;
      endcase
    end
  end

  assign dest_w     = cls_w.link_fixed ? FIXED_RD : link_rd_i;
  assign link_req_w = take_w && cls_w.link && (dest_w != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      npc_o      <= '0;
      taken_o    <= 1'b0;
      link_we_o  <= 1'b0;
      link_rd_o  <= '0;
      link_val_o <= '0;
    end else begin
      npc_o      <= next_w;
      taken_o    <= take_w;
      link_we_o  <= link_req_w;
      link_rd_o  <= link_req_w ? dest_w : '0;
      link_val_o <= seq_w;
    end
  end

endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk
  import npc_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int RA_W     = 5,
  parameter int LINK_IDX = 31
) (
  input logic              clk,
  input logic              rst_n,
  input logic [XLEN-1:0]   pc_i,
  input logic [XFER_W-1:0] xfer_i,
  input logic [XLEN-1:0]   rs_val_i,
  input logic [XLEN-1:0]   rt_val_i,
  input logic [XLEN-1:0]   jreg_i,
  input logic [XLEN-1:0]   npc_o,
  input logic              taken_o,
  input logic              link_we_o,
  input logic [RA_W-1:0]   link_rd_o,
  input logic [XLEN-1:0]   link_val_o,
  input logic              take_w,
  input logic              link_req_w
);

  logic primed;
  always_ff @(posedge clk) begin
    if (!rst_n) primed <= 1'b0;
    else        primed <= 1'b1;
  end

  assert_link_needs_take_R8: assert property (@(posedge clk) disable iff (!rst_n)
    link_req_w |-> take_w);

  assert_link_rd_nonzero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    link_we_o |-> (link_rd_o != '0));

  assert_fallthru_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && !taken_o) |-> (npc_o == $past(pc_i) + XLEN'(4) && !link_we_o));

  assert_eq_branch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && $past(xfer_i) == XF_BR_EQ) |->
      (taken_o == ($past(rs_val_i) == $past(rt_val_i))));

  assert_jreg_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && $past(xfer_i) == XF_JREG) |-> (taken_o && npc_o == $past(jreg_i)));

  assert_jdir_link_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && $past(xfer_i) == XF_JDIR_LINK) |->
      (link_we_o && link_rd_o == RA_W'(LINK_IDX)));

  assert_unused_code_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && $past(xfer_i) > XF_JREG_LINK) |-> !taken_o);

  assert_link_value_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && link_we_o) |-> (link_val_o == $past(pc_i) + XLEN'(4)));

endmodule

bind npc_unit npc_unit_chk #(.XLEN(XLEN), .RA_W(RA_W), .LINK_IDX(LINK_IDX)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pc_i       (pc_i),
  .xfer_i     (xfer_i),
  .rs_val_i   (rs_val_i),
  .rt_val_i   (rt_val_i),
  .jreg_i     (jreg_i),
  .npc_o      (npc_o),
  .taken_o    (taken_o),
  .link_we_o  (link_we_o),
  .link_rd_o  (link_rd_o),
  .link_val_o (link_val_o),
  .take_w     (take_w),
  .link_req_w (link_req_w)
);

// File: tb/tb_npc_unit.sv
`timescale 1ns/1ps
module tb_npc_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pc_i = '0;
  logic [3:0]  xfer_i = '0;
  logic [31:0] rs_val_i = '0;
  logic [31:0] rt_val_i = '0;
  logic [15:0] off_i = '0;
  logic [25:0] jtgt_i = '0;
  logic [31:0] jreg_i = '0;
  logic [4:0]  link_rd_i = '0;
  logic [31:0] npc_o;
  logic        taken_o;
  logic        link_we_o;
  logic [4:0]  link_rd_o;
  logic [31:0] link_val_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  npc_unit dut (
    .clk(clk), .rst_n(rst_n), .pc_i(pc_i), .xfer_i(xfer_i),
    .rs_val_i(rs_val_i), .rt_val_i(rt_val_i), .off_i(off_i),
    .jtgt_i(jtgt_i), .jreg_i(jreg_i), .link_rd_i(link_rd_i),
    .npc_o(npc_o), .taken_o(taken_o), .link_we_o(link_we_o),
    .link_rd_o(link_rd_o), .link_val_o(link_val_o)
  );

  logic [31:0] e_npc, e_val;
  logic        e_tk, e_we;
  logic [4:0]  e_rd;

  task automatic model();
    logic [31:0] seq;
    logic        tk;
    int signed   s;
    seq = pc_i + 32'd4;
    s = rs_val_i;
    e_val = seq;
    e_we = 1'b0;
    e_rd = 5'd0;
    case (xfer_i)
      4'd1: tk = (rs_val_i == rt_val_i);
      4'd2: tk = (rs_val_i != rt_val_i);
      4'd3: tk = (s > 0);
      4'd4: tk = (s < 0);
      4'd5: tk = (s >= 0);
      4'd6: tk = (s <= 0);
      default: tk = (xfer_i >= 4'd7 && xfer_i <= 4'd10);
    endcase
    e_tk = tk;
    if (!tk) e_npc = seq;
    else if (xfer_i <= 4'd6) e_npc = seq + ({{16{off_i[15]}}, off_i} * 32'd4);
    else if (xfer_i <= 4'd8) e_npc = {seq[31:28], jtgt_i, 2'b00};
    else e_npc = jreg_i;
    if (xfer_i == 4'd8) begin e_we = 1'b1; e_rd = 5'd31; end
    if (xfer_i == 4'd10 && link_rd_i != 5'd0) begin e_we = 1'b1; e_rd = link_rd_i; end
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp_v,
                     input string what);
    checks++;
    if (act !== exp_v) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h (code %0d pc %h)", tag, what, act, exp_v,
               xfer_i, pc_i);
    end
  endtask

  task automatic tag_of(output string t);
    if (xfer_i == 4'd1 || xfer_i == 4'd2) t = "R2";
    else if (xfer_i >= 4'd3 && xfer_i <= 4'd6) t = "R3";
    else if (xfer_i == 4'd7) t = "R5";
    else if (xfer_i == 4'd8) t = "R6";
    else if (xfer_i == 4'd9) t = "R7";
    else if (xfer_i == 4'd10) t = "R8";
    else t = "R9";
  endtask

  // Inputs are set at a falling edge; results are read at the next falling edge.
  task automatic run_vec(input string force_tag);
    string t;
    model();
    tag_of(t);
    if (force_tag != "") t = force_tag;
    @(negedge clk);
    chk(t, npc_o, e_npc, "npc");
    chk(t, {31'd0, taken_o}, {31'd0, e_tk}, "taken");
    chk(e_tk ? t : "R4", {31'd0, link_we_o}, {31'd0, e_we}, "link_we");
    if (e_we) begin
      chk(t, {27'd0, link_rd_o}, {27'd0, e_rd}, "link_rd");
      chk(t, link_val_o, e_val, "link_val");
    end
  endtask

  logic [31:0] opv [6] = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 32'h8000_0000, 32'h5};
  logic [15:0] offv [5] = '{16'h0, 16'h1, 16'hFFFF, 16'h7FFF, 16'h8000};
  logic [31:0] pcv [4] = '{32'h0040_0020, 32'hFFFF_FFFC, 32'h0FFF_FFFC, 32'h0};

  initial begin
    // R1: outputs idle during reset even with a jump presented
    xfer_i = 4'd9; jreg_i = 32'hDEAD_BEE0; pc_i = 32'h100;
    repeat (3) @(negedge clk);
    chk("R1", npc_o, 32'd0, "npc");
    chk("R1", {31'd0, taken_o}, 32'd0, "taken");
    chk("R1", {31'd0, link_we_o}, 32'd0, "link_we");
    rst_n = 1'b1;

    // Branch sweep: R2, R3 (and R4 when not taken)
    for (int c = 1; c <= 6; c++)
      for (int p = 0; p < 4; p++)
        for (int o = 0; o < 5; o++)
          for (int a = 0; a < 6; a++)
            for (int b = 0; b < 6; b++) begin
              if (c >= 3 && b > 0) continue;
              xfer_i = 4'(c); pc_i = pcv[p]; off_i = offv[o];
              rs_val_i = opv[a]; rt_val_i = opv[b];
              run_vec("");
            end

    // Every code with jump fields and link destinations: R5..R9
    for (int c = 0; c < 16; c++)
      for (int p = 0; p < 4; p++)
        for (int r = 0; r < 32; r += 7) begin
          xfer_i = 4'(c); pc_i = pcv[p]; link_rd_i = 5'(r);
          jtgt_i = 26'h3FF_FFFF ^ 26'(r * 26'h12345);
          jreg_i = 32'h8000_0000 + 32'(r * 4);
          rs_val_i = 32'h0; rt_val_i = 32'h0; off_i = 16'h8000;
          run_vec("");
        end

    // R8: link to register 0 is suppressed but the jump still happens
    xfer_i = 4'd10; link_rd_i = 5'd0; jreg_i = 32'h0000_1230; pc_i = 32'h40;
    run_vec("R8");
    xfer_i = 4'd10; link_rd_i = 5'd31; run_vec("R8");

    // R4: sequential path with no transfer
    xfer_i = 4'd0; pc_i = 32'h0040_0044; run_vec("R4");

    // R11: wraparound of sequential, branch and jump sums
    xfer_i = 4'd0; pc_i = 32'hFFFF_FFFC; run_vec("R11");
    xfer_i = 4'd1; pc_i = 32'hFFFF_FFF8; off_i = 16'h0002; rs_val_i = 0; rt_val_i = 0;
    run_vec("R11");
    xfer_i = 4'd5; pc_i = 32'h0000_0000; off_i = 16'h8000; run_vec("R11");
    xfer_i = 4'd7; pc_i = 32'hEFFF_FFFC; jtgt_i = 26'h1; run_vec("R11");

    // R10: output holds until the next rising edge
    xfer_i = 4'd9; jreg_i = 32'h0000_AAA0; run_vec("R10");
    jreg_i = 32'h0000_BBB0;
    #2;
    chk("R10", npc_o, 32'h0000_AAA0, "npc held");
    @(negedge clk);
    chk("R10", npc_o, 32'h0000_BBB0, "npc updated");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule